// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a CPU core. It collects a reset request and a set of interrupt request lines, and qualifies each interrupt with its own enable bit, a global enable flag and a protection input. It picks the most urgent qualified request and hands the core a program-memory vector address together with a one-cycle accept strobe. Each request line is built as either level-following or edge-latched, chosen by a parameter mask.

The controller owns the global enable flag. Accepting any request clears the flag. A return-from-interrupt from the core sets it again, and software may also set or clear it directly. Setting it inside a handler lets a further enabled request preempt that handler once the core has acknowledged the earlier acceptance. Two control bits choose, separately, whether the interrupt table and the reset vector start at address zero or at a configurable boot-section base.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Interrupt source k (k = 0..N-1) occupies table slot k+1 and its vector is base + 2*(k+1). The base is 0 when `vec_sel_i` is 0 and BOOT_BASE when it is 1. `src_o` reports the slot number.
- R2: The reset request occupies slot 0 and its vector is 0, or BOOT_BASE when `rst_boot_i` is 1. `vec_sel_i` has no effect on the reset vector.
- R3: An interrupt source is accepted only while its bit in `src_en_i` is 1 and `gie_o` is 1. A masked request that stays pending is accepted as soon as it becomes qualified.
- R4: When several qualified requests are present, the lowest slot wins. The reset request outranks every interrupt.
- R5: An acceptance raises `take_o` for exactly one cycle, with `vec_o` and `src_o` valid in that cycle. `gie_o` reads 0 in that same cycle.
- R6: A pulse on `gie_set_i` sets `gie_o` and a pulse on `gie_clr_i` clears it. If both are asserted, clear wins. Setting the flag inside a handler allows a new request to preempt that handler.
- R7: A pulse on `reti_i` sets `gie_o` to 1 in the following cycle.
- R8: While `protect_i` is 1, no interrupt source is accepted. The reset request is still accepted.
- R9: A source whose bit in LEVEL_MASK is 0 latches a rising edge of its line. The latched request stays pending until it is accepted, even after the line drops. A source whose bit in LEVEL_MASK is 1 is pending only while its line is high.
- R10: After an acceptance, no interrupt is accepted until `ack_i` has been seen, even if `gie_o` is 1.
- R11: A rising edge on `rst_req_i` is accepted regardless of the enables, the global flag, protection and an outstanding acknowledge. Accepting it clears `gie_o` and discards every latched interrupt request.
- R12: A level source line that goes high before clock edge E is accepted at E, so `take_o` is seen after E. An edge-latched source or the reset request is accepted one edge later.
- R13: After reset, `take_o` is 0, `gie_o` is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line_i | input | N | Interrupt request lines, bit k is source k |
| src_en_i | input | N | Per-source enable bits |
| rst_req_i | input | 1 | Reset request line, rising edge is taken |
| vec_sel_i | input | 1 | Places the interrupt table at BOOT_BASE when 1 |
| rst_boot_i | input | 1 | Places the reset vector at BOOT_BASE when 1 |
| protect_i | input | 1 | Blocks interrupt acceptance when 1 |
| gie_set_i | input | 1 | Software sets the global enable |
| gie_clr_i | input | 1 | Software clears the global enable |
| reti_i | input | 1 | Core executed a return-from-interrupt |
| ack_i | input | 1 | Core acknowledges the last acceptance |
| take_o | output | 1 | One-cycle accept strobe |
| vec_o | output | ADDR_W | Vector address of the accepted request |
| src_o | output | $clog2(N+1) | Slot of the accepted request, 0 for reset |
| gie_o | output | 1 | Global interrupt enable flag |

## Verification
A level source is due on `take_o` one edge after its line rises. An edge-latched source or a reset request is due two edges after, and a change to `gie_o` from set, clear or return shows one edge after the pulse. Inputs change on the falling edge, and the bench predicts for each step the exact edge on which the strobe must appear, given the latency class of the source that wins. It requires the strobe to be low on every other sampled step. After a preemption, the winner on the first edge can differ from the priority winner, because a level source reaches the selection one edge earlier. The pair sweep therefore computes the first winner from both latency and slot order, then drains whichever latched loser remains and checks that it is taken once the acknowledge arrives.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VEC_STEP = 2;

  typedef enum logic [1:0] {
    GIE_KEEP  = 2'd0,
    GIE_DROP  = 2'd1,
    GIE_RAISE = 2'd2
  } gie_op_e;
endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int unsigned   N          = 8,
  parameter logic [N-1:0]  LEVEL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] pend_o
);

  for (genvar k = 0; k < N; k++) begin : g_src
    if (LEVEL_MASK[k]) begin : g_level
      logic unused_clr;
      assign unused_clr = clr_i[k];
      assign pend_o[k]  = line_i[k];
    end else begin : g_edge
      logic prev_q, prev_n;
      logic held_q, held_n;
      logic rise;

      always_comb begin
        rise   = line_i[k] & ~prev_q;
        prev_n = line_i[k];
        held_n = rise | (held_q & ~clr_i[k] & ~flush_i);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          held_q <= 1'b0;
        end else begin
          prev_q <= prev_n;
          held_q <= held_n;
        end
      end

      assign pend_o[k] = held_q;

      // R9: a latched request survives until it is serviced or flushed
      p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !clr_i[k] && !flush_i) |=> held_q);
    end
  end

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
        any_o      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vic_vecgen.sv
module vic_vecgen
  import vic_pkg::*;
#(
  parameter int unsigned      N         = 8,
  parameter int unsigned      ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = '0,
  localparam int unsigned     IW        = $clog2(N),
  localparam int unsigned     SW        = $clog2(N + 1)
) (
  input  logic              vec_sel_i,
  input  logic              rst_boot_i,
  input  logic              is_rst_i,
  input  logic [IW-1:0]     idx_i,
  output logic [SW-1:0]     slot_o,
  output logic [ADDR_W-1:0] vec_o
);

  logic [ADDR_W-1:0] base;

  always_comb begin
    if (is_rst_i) begin
      slot_o = '0;
      base   = rst_boot_i ? BOOT_BASE : '0;
    end else begin
      slot_o = SW'(idx_i) + SW'(1);
      base   = vec_sel_i ? BOOT_BASE : '0;
    end
    vec_o = base + ADDR_W'(slot_o) * ADDR_W'(VEC_STEP);
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned       N          = 8,
  parameter logic [N-1:0]      LEVEL_MASK = 8'hF0,
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 16'hF000,
  localparam int unsigned      IW         = $clog2(N),
  localparam int unsigned      SW         = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_line_i,
  input  logic [N-1:0]      src_en_i,
  input  logic              rst_req_i,
  input  logic              vec_sel_i,
  input  logic              rst_boot_i,
  input  logic              protect_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              reti_i,
  input  logic              ack_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [SW-1:0]     src_o,
  output logic              gie_o
);

  logic              rst_prev_q, rst_prev_n;
  logic              rst_pend_q, rst_pend_n;
  logic              gie_q, gie_n;
  logic              busy_q, busy_n;
  logic              take_q, take_n;
  logic [ADDR_W-1:0] vec_q, vec_n;
  logic [SW-1:0]     src_q, src_n;

  logic              rst_fire, irq_fire, irq_ok;
  logic [N-1:0]      pend, qual, grant, clr_vec;
  logic [IW-1:0]     win_idx;
  logic              win_any;
  logic [SW-1:0]     slot;
  logic [ADDR_W-1:0] vec_calc;
  gie_op_e           gie_op;

  vic_pending #(.N(N), .LEVEL_MASK(LEVEL_MASK)) u_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (irq_line_i),
    .clr_i   (clr_vec),
    .flush_i (rst_fire),
    .pend_o  (pend)
  );

  vic_prio #(.N(N)) u_prio (
    .req_i   (qual),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (win_any)
  );

  vic_vecgen #(.N(N), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_vecgen (
    .vec_sel_i  (vec_sel_i),
    .rst_boot_i (rst_boot_i),
    .is_rst_i   (rst_fire),
    .idx_i      (win_idx),
    .slot_o     (slot),
    .vec_o      (vec_calc)
  );

  // Request qualification and arbitration
  always_comb begin
    rst_prev_n = rst_req_i;
    rst_fire   = rst_pend_q & ~take_q;
    rst_pend_n = (rst_req_i & ~rst_prev_q) | (rst_pend_q & ~rst_fire);
    irq_ok     = gie_q & ~protect_i & ~busy_q & ~take_q;
    qual       = pend & src_en_i & {N{irq_ok}};
    irq_fire   = win_any & ~rst_fire;
    clr_vec    = irq_fire ? grant : '0;
    take_n     = rst_fire | irq_fire;
  end

  // Global enable, outstanding acknowledge, output staging
  always_comb begin
    if (take_n)                   gie_op = GIE_DROP;
    else if (gie_clr_i)           gie_op = GIE_DROP;
    else if (reti_i || gie_set_i) gie_op = GIE_RAISE;
    else                          gie_op = GIE_KEEP;

    case (gie_op)
      GIE_DROP:  gie_n = 1'b0;
      GIE_RAISE: gie_n = 1'b1;
      default:   gie_n = gie_q;
    endcase

    if (take_n)     busy_n = 1'b1;
    else if (ack_i) busy_n = 1'b0;
    else            busy_n = busy_q;

    vec_n = take_n ? vec_calc : vec_q;
    src_n = take_n ? slot     : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_prev_q <= 1'b0;
      rst_pend_q <= 1'b0;
      gie_q      <= 1'b0;
      busy_q     <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= '0;
      src_q      <= '0;
    end else begin
      rst_prev_q <= rst_prev_n;
      rst_pend_q <= rst_pend_n;
      gie_q      <= gie_n;
      busy_q     <= busy_n;
      take_q     <= take_n;
      vec_q      <= vec_n;
      src_q      <= src_n;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign src_o  = src_q;
  assign gie_o  = gie_q;

  // R4: the arbiter never grants two sources at once
  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5: the accept strobe lasts one cycle
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  // R5: global enable reads low while the strobe is up
  p_gie_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gie_o);

  // R7: a return with no competing acceptance or clear raises the flag
  p_reti_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_n && !gie_clr_i) |=> gie_o);

  // R3: an interrupt slot was qualified on the edge it was taken
  p_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o != '0) |->
      ($past(gie_o) && !$past(protect_i) &&
       ((($past(src_en_i) >> (src_o - SW'(1))) & N'(1)) != '0)));

  // R10: waiting for acknowledge blocks interrupt slots
  p_wait_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_i) |=> (!take_o || src_o == '0));

endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int unsigned N     = 8;
  localparam logic [7:0]  LVL   = 8'hF0;
  localparam logic [15:0] BOOTB = 16'hF000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_line, src_en;
  logic        rst_req, vsel, rboot, prot, gset, gclr, reti, ack;
  logic        take;
  logic [15:0] vec;
  logic [3:0]  src;
  logic        gie;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.N(N), .LEVEL_MASK(LVL), .ADDR_W(16), .BOOT_BASE(BOOTB)) u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_line_i(irq_line), .src_en_i(src_en),
    .rst_req_i(rst_req), .vec_sel_i(vsel), .rst_boot_i(rboot), .protect_i(prot),
    .gie_set_i(gset), .gie_clr_i(gclr), .reti_i(reti), .ack_i(ack),
    .take_o(take), .vec_o(vec), .src_o(src), .gie_o(gie)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expvec(input int slot, input bit boot);
    return (boot ? int'(BOOTB) : 0) + slot * 2;
  endfunction

  function automatic int lat(input int k);
    return LVL[k] ? 1 : 2;
  endfunction

  // acknowledge, then return, leaving the flag set and nothing outstanding
  task automatic finish_handler();
    ack = 1'b1; step(); ack = 1'b0;
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  task automatic fire_one(input int k, input bit vs);
    vsel = vs;
    irq_line[k] = 1'b1;
    for (int c = 1; c <= 3; c++) begin
      step();
      if (c == 1 && !LVL[k]) irq_line[k] = 1'b0;
      chk(take == (c == lat(k)), "R12 strobe timing", take, c == lat(k));
      if (c == lat(k)) begin
        chk(vec == expvec(k + 1, vs), "R1 vector", vec, expvec(k + 1, vs));
        chk(src == k + 1, "R1 slot", src, k + 1);
        chk(gie == 1'b0, "R5 flag cleared", gie, 0);
      end
    end
    irq_line[k] = 1'b0;
    ack = 1'b1; step(); ack = 1'b0;
    chk(gie == 1'b0, "R7 flag held before return", gie, 0);
    reti = 1'b1; step(); reti = 1'b0;
    chk(gie == 1'b1, "R7 return sets flag", gie, 1);
  endtask

  task automatic pair(input int i, input int j);
    int w, l, wl, left;
    if (LVL[i] || !LVL[j]) begin w = i; l = j; end
    else begin w = j; l = i; end
    wl   = lat(w);
    left = LVL[l] ? 0 : l + 1;
    irq_line[i] = 1'b1;
    irq_line[j] = 1'b1;
    for (int c = 1; c <= 2; c++) begin
      step();
      if (c == 1) irq_line = '0;
      chk(take == (c == wl), "R4 pair strobe", take, c == wl);
      if (c == wl) chk(src == w + 1, "R4 pair winner", src, w + 1);
    end
    ack = 1'b1; gset = 1'b1; step(); ack = 1'b0; gset = 1'b0;
    step();
    chk(take == (left != 0), "R9 latched loser served", take, left != 0);
    if (left != 0) chk(src == left, "R9 loser slot", src, left);
    step();
    chk(take == 1'b0, "R10 no repeat", take, 0);
    finish_handler();
  endtask

  initial begin
    rst_n = 1'b0; irq_line = '0; src_en = '1; rst_req = 0; vsel = 0; rboot = 0;
    prot = 0; gset = 0; gclr = 0; reti = 0; ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(take == 1'b0, "R13 reset strobe", take, 0);
    chk(gie == 1'b0, "R13 reset flag", gie, 0);
    src_en = '0; irq_line = '1; step(); irq_line = '0; step();
    chk(take == 1'b0, "R13 nothing pending", take, 0);
    src_en = '1; step();
    chk(take == 1'b0, "R3 flag low blocks", take, 0);

    gset = 1'b1; gclr = 1'b1; step(); gset = 1'b0; gclr = 1'b0;
    chk(gie == 1'b0, "R6 clear wins", gie, 0);
    // edge-latched lines fired above while masked; flush them with a reset request
    rst_req = 1'b1; step(); rst_req = 1'b0; step();
    chk(take && src == 0, "R11 reset taken", take, 1);
    ack = 1'b1; step(); ack = 1'b0;
    gset = 1'b1; step(); gset = 1'b0;
    chk(gie == 1'b1, "R6 set flag", gie, 1);
    step();
    chk(take == 1'b0, "R11 flush of latched", take, 0);

    for (int vs = 0; vs < 2; vs++)
      for (int k = 0; k < 8; k++) fire_one(k, vs[0]);

    vsel = 1'b0;
    for (int i = 0; i < 8; i++)
      for (int j = i + 1; j < 8; j++) pair(i, j);

    // R3: per-source enable masks, request waits, then is served
    for (int k = 0; k < 8; k++) begin
      src_en[k] = 1'b0;
      irq_line[k] = 1'b1; step();
      if (!LVL[k]) irq_line[k] = 1'b0;
      step(); step();
      chk(take == 1'b0, "R3 enable masks", take, 0);
      src_en[k] = 1'b1; step();
      chk(take && src == k + 1, "R3 served after enable", src, k + 1);
      irq_line[k] = 1'b0;
      finish_handler();
    end

    // R8: protection blocks interrupts
    prot = 1'b1; irq_line[5] = 1'b1; step(); step(); step();
    chk(take == 1'b0, "R8 protection blocks", take, 0);
    prot = 1'b0; step();
    chk(take && src == 6, "R8 served after release", src, 6);
    irq_line[5] = 1'b0; finish_handler();

    // R6: flag cleared by software blocks, then set lets it through
    gclr = 1'b1; step(); gclr = 1'b0;
    chk(gie == 1'b0, "R6 software clear", gie, 0);
    irq_line[2] = 1'b1; step(); irq_line[2] = 1'b0; step(); step();
    chk(take == 1'b0, "R3 flag low masks", take, 0);
    gset = 1'b1; step(); gset = 1'b0; step();
    chk(take && src == 3, "R6 served after set", src, 3);
    finish_handler();

    // R10 and R6 nesting: handler re-enables, preemption waits for acknowledge
    irq_line[4] = 1'b1; step();
    chk(take && src == 5, "R12 level one edge", src, 5);
    irq_line[4] = 1'b0;
    gset = 1'b1; step(); gset = 1'b0;
    irq_line[0] = 1'b1; step(); irq_line[0] = 1'b0; step(); step();
    chk(take == 1'b0, "R10 waits for acknowledge", take, 0);
    ack = 1'b1; step(); ack = 1'b0;
    chk(take == 1'b0, "R10 acknowledge edge", take, 0);
    step();
    chk(take && src == 1, "R6 nested preemption", src, 1);
    finish_handler();

    // R4 and R11: reset beats a simultaneous latched source and flushes it
    irq_line[0] = 1'b1; rst_req = 1'b1; step();
    irq_line[0] = 1'b0; rst_req = 1'b0; step();
    chk(take && src == 0, "R4 reset outranks", src, 0);
    chk(gie == 1'b0, "R11 reset clears flag", gie, 0);
    ack = 1'b1; gset = 1'b1; step(); ack = 1'b0; gset = 1'b0;
    step();
    chk(take == 1'b0, "R11 latched source discarded", take, 0);

    // R2 and R11: reset ignores qualification, own base select
    for (int b = 0; b < 2; b++) begin
      irq_line[4] = 1'b1; step(); irq_line[4] = 1'b0;
      src_en = '0; prot = 1'b1; gclr = 1'b1;
      vsel = ~b[0]; rboot = b[0];
      rst_req = 1'b1; step(); gclr = 1'b0; rst_req = 1'b0; step();
      chk(take && src == 0, "R11 reset while busy", take, 1);
      chk(vec == expvec(0, b[0]), "R2 reset vector", vec, expvec(0, b[0]));
      src_en = '1; prot = 1'b0;
      finish_handler();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule